// File: doc/BRIEF.md
# System Power-On Sequencer

This block handles the handshake between a handheld system and its external power supply. While the system is off, it waits for a wake event. A wake event is a press of the on-button or a wake request from an interrupt source. When power-good is high, it raises the power chip-select so the supply switches the main rails on. It then waits for the supply's rail status to come up, and gives up after a programmable number of cycles if the rail does not rise.

Once the system is on, software can request a power-down. The chip-select then falls, and that falling edge frames the command the supply latches. The block returns to off when the rail status drops. It also keeps two interrupt flags with different priorities. The high-priority flag is an emergency: power-good was lost while the system was running. The low-priority flag reports an ordinary supply status change. A third flag marks a failed wake attempt. All three flags are sticky and are cleared by writing 1.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset the state output reads OFF (encoding OFF=0, WAKING=1, ON=2, SHUTDOWN=3), `pwr_cs` is low and all three flags are low.
- R2: In OFF with `pwr_good` high, either a rising edge of the synchronised `btn_in` or a high `wake_req` moves the block to WAKING, and `pwr_cs` goes high.
- R3: In OFF with `pwr_good` low, neither the button nor `wake_req` leaves OFF, and `pwr_cs` stays low.
- R4: In WAKING, a high `rail_ok` at a clock edge moves the block to ON, and `pwr_cs` stays high in ON.
- R5: If `rail_ok` stays low, WAKING lasts exactly `timeout_cfg` cycles, with a value of 0 treated as 1. The block then returns to OFF with `pwr_cs` low and sets `wake_err`.
- R6: Holding `btn_in` high causes one wake attempt only. After a timeout, the block stays in OFF while the button is still held.
- R7: `pd_req` in ON moves the block to SHUTDOWN and drops `pwr_cs`. SHUTDOWN goes to OFF once `rail_ok` is low. `pd_req` in OFF has no effect.
- R8: A falling edge of `pwr_good` while in ON sets `emerg_irq`. The same fall while in OFF does not set it.
- R9: A rising edge of the synchronised `stat_in` sets `stat_irq`. A level held high does not set it again after it is cleared.
- R10: The flags are sticky. A 1 on `flag_clr` bit 0 clears `emerg_irq`, bit 1 clears `stat_irq` and bit 2 clears `wake_err`. A set and a clear in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_in | input | 1 | On-button, asynchronous |
| wake_req | input | 1 | Wake request from an interrupt source |
| pwr_good | input | 1 | Supply power-good status |
| stat_in | input | 1 | Supply status-change line, asynchronous |
| rail_ok | input | 1 | Main rail status from the supply |
| pd_req | input | 1 | Software power-down request pulse |
| timeout_cfg | input | TW | Wake timeout in cycles |
| flag_clr | input | 3 | Write-1-to-clear strobes for the flags |
| pwr_cs | output | 1 | Power chip-select to the supply |
| state_o | output | 2 | Sequencer state |
| emerg_irq | output | 1 | Emergency flag: power-good lost while on |
| stat_irq | output | 1 | Supply status-change flag |
| wake_err | output | 1 | Wake timeout error flag |

## Verification
The bench builds the block with TW=4 and two synchroniser stages. At that width, every timeout value from 0 to 15 can be swept. For each value, the bench counts the cycles spent in WAKING and compares the count with the programmed value. Rail arrival is swept over several delays within the window. The bench also steps through the emergency, status and clear orderings, including a set and a clear landing in the same cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        PS_OFF      = 2'd0,
        PS_WAKING   = 2'd1,
        PS_ON       = 2'd2,
        PS_SHUTDOWN = 2'd3
    } pwr_state_e;

    localparam int FLAG_EMERG = 0;
    localparam int FLAG_STAT  = 1;
    localparam int FLAG_ERR   = 2;
    localparam int NUM_FLAGS  = 3;

    function automatic logic rails_requested(input pwr_state_e s);
        return (s == PS_WAKING) || (s == PS_ON);
    endfunction

endpackage

// File: rtl/pwr_seq_edge_sync.sv
module pwr_seq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/pwr_seq_flags.sv
module pwr_seq_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)           flag_o[i] <= 1'b0;
                else if (set_i[i]) flag_o[i] <= 1'b1;
                else if (clr_i[i]) flag_o[i] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          btn_rise,
    input  logic          wake_req,
    input  logic          pwr_good,
    input  logic          rail_ok,
    input  logic          pd_req,
    input  logic [TW-1:0] timeout_cfg,
    output pwr_state_e    state,
    output logic          emerg_set,
    output logic          err_set
);
    localparam int CW = TW + 1;

    pwr_state_e    nxt;
    logic [TW-1:0] cnt;
    logic          pg_last;
    logic          expired;

    assign expired = ({1'b0, cnt} + CW'(1)) >= {1'b0, timeout_cfg};

    always_comb begin
        nxt     = state;
        err_set = 1'b0;
        unique case (state)
            PS_OFF: begin
                if (pwr_good && (btn_rise || wake_req)) nxt = PS_WAKING;
            end
            PS_WAKING: begin
                if (rail_ok) begin
                    nxt = PS_ON;
                end else if (expired) begin
                    nxt     = PS_OFF;
                    err_set = 1'b1;
                end
            end
            PS_ON: begin
                if (pd_req) nxt = PS_SHUTDOWN;
            end
            PS_SHUTDOWN: begin
                if (!rail_ok) nxt = PS_OFF;
            end
            default: nxt = PS_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PS_OFF;
            cnt     <= '0;
            pg_last <= 1'b0;
        end else begin
            state   <= nxt;
            pg_last <= pwr_good;
            if (state == PS_WAKING) cnt <= cnt + TW'(1);
            else                    cnt <= '0;
        end
    end

    assign emerg_set = (state == PS_ON) && pg_last && !pwr_good;
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int TW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          btn_in,
    input  logic          wake_req,
    input  logic          pwr_good,
    input  logic          stat_in,
    input  logic          rail_ok,
    input  logic          pd_req,
    input  logic [TW-1:0] timeout_cfg,
    input  logic [2:0]    flag_clr,
    output logic          pwr_cs,
    output logic [1:0]    state_o,
    output logic          emerg_irq,
    output logic          stat_irq,
    output logic          wake_err
);
    logic                 btn_rise;
    logic                 stat_rise;
    logic                 emerg_set;
    logic                 err_set;
    pwr_state_e           state;
    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] flags;

    pwr_seq_edge_sync #(.STAGES(SYNC_STAGES)) u_btn_sync (
        .clk(clk), .rst(rst), .async_in(btn_in), .rise(btn_rise)
    );

    pwr_seq_edge_sync #(.STAGES(SYNC_STAGES)) u_stat_sync (
        .clk(clk), .rst(rst), .async_in(stat_in), .rise(stat_rise)
    );

    pwr_seq_fsm #(.TW(TW)) u_fsm (
        .clk(clk), .rst(rst), .btn_rise(btn_rise), .wake_req(wake_req),
        .pwr_good(pwr_good), .rail_ok(rail_ok), .pd_req(pd_req),
        .timeout_cfg(timeout_cfg), .state(state),
        .emerg_set(emerg_set), .err_set(err_set)
    );

    always_comb begin
        set_vec             = '0;
        set_vec[FLAG_EMERG] = emerg_set;
        set_vec[FLAG_STAT]  = stat_rise;
        set_vec[FLAG_ERR]   = err_set;
    end

    pwr_seq_flags #(.N(NUM_FLAGS)) u_flags (
        .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(flag_clr), .flag_o(flags)
    );

    assign pwr_cs    = rails_requested(state);
    assign state_o   = state;
    assign emerg_irq = flags[FLAG_EMERG];
    assign stat_irq  = flags[FLAG_STAT];
    assign wake_err  = flags[FLAG_ERR];
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk #(
    parameter int TW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          pwr_good,
    input logic          rail_ok,
    input logic          pd_req,
    input logic [2:0]    flag_clr,
    input logic          pwr_cs,
    input logic [1:0]    state_o,
    input logic          emerg_irq,
    input logic          stat_irq,
    input logic          wake_err
);
    logic pg_seen;
    always_ff @(posedge clk) begin
        if (rst) pg_seen <= 1'b0;
        else     pg_seen <= pwr_good;
    end

    a_r3_no_wake_without_pg: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd0 && !pwr_good) |=> (state_o == 2'd0 && !pwr_cs));

    a_r4_on_needs_rail: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd1 && !rail_ok) |=> (state_o != 2'd2));

    a_r5_err_lands_in_off: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_err) |-> (state_o == 2'd0 && !pwr_cs));

    a_r7_pd_drops_cs: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd2 && pd_req) |=> (state_o == 2'd3 && !pwr_cs));

    a_r8_emerg_on_drop: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd2 && pg_seen && !pwr_good) |=> emerg_irq);

    a_r10_emerg_sticky: assert property (@(posedge clk) disable iff (rst)
        (emerg_irq && !flag_clr[0]) |=> emerg_irq);

    a_r10_stat_sticky: assert property (@(posedge clk) disable iff (rst)
        (stat_irq && !flag_clr[1]) |=> stat_irq);

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (wake_err && !flag_clr[2]) |=> wake_err);
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.TW(TW)) u_chk (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .rail_ok(rail_ok),
    .pd_req(pd_req), .flag_clr(flag_clr), .pwr_cs(pwr_cs),
    .state_o(state_o), .emerg_irq(emerg_irq), .stat_irq(stat_irq),
    .wake_err(wake_err)
);

// File: tb/pwr_seq_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb;
    localparam int TW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_in = 0, wake_req = 0, pwr_good = 1, stat_in = 0, rail_ok = 0, pd_req = 0;
    logic [TW-1:0] timeout_cfg = 4'd15;
    logic [2:0] flag_clr = 3'b000;
    logic pwr_cs, emerg_irq, stat_irq, wake_err;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pwr_seq_ctrl #(.TW(TW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .btn_in(btn_in), .wake_req(wake_req),
        .pwr_good(pwr_good), .stat_in(stat_in), .rail_ok(rail_ok),
        .pd_req(pd_req), .timeout_cfg(timeout_cfg), .flag_clr(flag_clr),
        .pwr_cs(pwr_cs), .state_o(state_o), .emerg_irq(emerg_irq),
        .stat_irq(stat_irq), .wake_err(wake_err)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_all();
        flag_clr = 3'b111;
        tick();
        flag_clr = 3'b000;
    endtask

    task automatic wake_pulse();
        wake_req = 1;
        tick();
        wake_req = 0;
    endtask

    task automatic go_on();
        timeout_cfg = 4'd15;
        wake_pulse();
        rail_ok = 1;
        tick();
    endtask

    task automatic go_off();
        pd_req = 1;
        tick();
        pd_req = 0;
        rail_ok = 0;
        tick();
    endtask

    initial begin
        int cyc;
        int expv;
        tick(3);
        rst = 0;
        #0;
        // R1 reset state
        check("R1 state", state_o, 0);
        check("R1 pwr_cs", pwr_cs, 0);
        check("R1 flags", {emerg_irq, stat_irq, wake_err}, 0);

        // R5 timeout sweep over every timeout value
        for (int t = 0; t < 16; t++) begin
            timeout_cfg = t[TW-1:0];
            wake_pulse();
            check("R2 wake_req enters WAKING", state_o, 1);
            cyc = 0;
            while (pwr_cs && cyc < 40) begin
                cyc++;
                tick();
            end
            expv = (t == 0) ? 1 : t;
            check("R5 waking cycles", cyc, expv);
            check("R5 back in OFF", state_o, 0);
            check("R5 wake_err set", wake_err, 1);
            clear_all();
            check("R10 wake_err cleared", wake_err, 0);
        end

        // R4 rail arrival sweep, R7 shutdown
        for (int k = 0; k < 5; k++) begin
            timeout_cfg = 4'd12;
            wake_pulse();
            tick(k);
            check("R4 still waking", state_o, 1);
            rail_ok = 1;
            tick();
            check("R4 ON", state_o, 2);
            check("R4 pwr_cs in ON", pwr_cs, 1);
            pd_req = 1;
            tick();
            pd_req = 0;
            check("R7 SHUTDOWN", state_o, 3);
            check("R7 pwr_cs low", pwr_cs, 0);
            tick(2);
            check("R7 waits rail drop", state_o, 3);
            rail_ok = 0;
            tick();
            check("R7 OFF after rail drop", state_o, 0);
            check("R4 no err", wake_err, 0);
        end

        // R7 pd_req in OFF ignored
        pd_req = 1;
        tick();
        pd_req = 0;
        check("R7 pd_req ignored in OFF", state_o, 0);

        // R3 no wake without power-good
        pwr_good = 0;
        wake_pulse();
        tick();
        check("R3 wake_req blocked", state_o, 0);
        btn_in = 1;
        tick(5);
        check("R3 button blocked", state_o, 0);
        check("R3 pwr_cs low", pwr_cs, 0);
        btn_in = 0;
        tick(4);
        check("R8 no emergency in OFF", emerg_irq, 0);
        pwr_good = 1;
        tick();

        // R2 button wake, R6 held button single attempt
        timeout_cfg = 4'd3;
        btn_in = 1;
        tick(3);
        check("R2 button enters WAKING", state_o, 1);
        tick(8);
        check("R6 timed out to OFF", state_o, 0);
        tick(10);
        check("R6 no repeat while held", state_o, 0);
        check("R6 pwr_cs low while held", pwr_cs, 0);
        btn_in = 0;
        tick(3);
        clear_all();

        // R8 emergency while on
        go_on();
        check("R8 in ON", state_o, 2);
        pwr_good = 0;
        tick();
        check("R8 emergency set", emerg_irq, 1);
        check("R8 stat unaffected", stat_irq, 0);
        pwr_good = 1;
        tick();
        // R10 set wins over clear
        pwr_good = 0;
        flag_clr = 3'b001;
        tick();
        flag_clr = 3'b000;
        check("R10 set beats clear", emerg_irq, 1);
        pwr_good = 1;
        tick(2);
        check("R10 emergency sticky", emerg_irq, 1);
        flag_clr = 3'b001;
        tick();
        flag_clr = 3'b000;
        check("R10 emergency cleared", emerg_irq, 0);
        go_off();
        check("R7 OFF", state_o, 0);

        // R9 status edge
        stat_in = 1;
        tick(4);
        check("R9 stat set", stat_irq, 1);
        check("R9 emerg untouched", emerg_irq, 0);
        flag_clr = 3'b010;
        tick();
        flag_clr = 3'b000;
        check("R10 stat cleared", stat_irq, 0);
        tick(5);
        check("R9 level does not reset flag", stat_irq, 0);
        stat_in = 0;
        tick(3);
        stat_in = 1;
        tick(4);
        check("R9 second edge", stat_irq, 1);
        stat_in = 0;
        clear_all();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule